// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This block rewrites one address bit for tiled surfaces that live in dual-channel interleaved memory. Address bit 6 picks the memory channel, so the tiled access pattern is spread over both channels by XORing bit 6 with a chosen set of higher address bits. The set of bits is selected by a swizzle mode. Software configures one mode for X-tiled surfaces and a separate mode for Y-tiled surfaces. Each access presents an address and its tiling type. The block returns the address with bit 6 adjusted.

The supported tap sets all include bit 9. Bits 10, 11 and 17 can be added to it. A "none" mode covers single-channel and asymmetric dual-channel memory. A distinct "unknown" mode marks a configuration that the block cannot honour. In that case the address passes through unchanged and a flag is raised. The block is purely combinational, with no clock and no state.

Top module: `bit6_swizzle`

## Requirements
- R1: When `tiling_i` is 0 (untiled) or 3 (reserved), `addr_o` equals `addr_i` and `unknown_o` is 0, whatever the two configured modes are.
- R2: Tiling code 1 (X) applies `x_mode_i` and ignores `y_mode_i`. Tiling code 2 (Y) applies `y_mode_i` and ignores `x_mode_i`.
- R3: Mode code 0 (none) gives `addr_o == addr_i`.
- R4: Mode code 1 sets output bit 6 to `addr[6] ^ addr[9]`.
- R5: Mode code 2 sets output bit 6 to `addr[6] ^ addr[9] ^ addr[10]`.
- R6: Mode code 3 sets output bit 6 to `addr[6] ^ addr[9] ^ addr[11]`.
- R7: Mode code 4 sets output bit 6 to `addr[6] ^ addr[9] ^ addr[10] ^ addr[11]`.
- R8: Mode code 5 sets output bit 6 to `addr[6] ^ addr[9] ^ addr[17]`.
- R9: Mode code 6 sets output bit 6 to `addr[6] ^ addr[9] ^ addr[10] ^ addr[17]`.
- R10: Mode code 7 (unknown), when it is the mode selected by the tiling type, drives `unknown_o` to 1 and gives `addr_o == addr_i`. For every other selected mode, `unknown_o` is 0.
- R11: Every output bit other than bit 6 equals the matching input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 36 | Address before swizzling |
| tiling_i | input | 2 | Tiling type: 0 untiled, 1 X, 2 Y, 3 reserved (treated as untiled) |
| x_mode_i | input | 3 | Swizzle mode applied to X-tiled accesses |
| y_mode_i | input | 3 | Swizzle mode applied to Y-tiled accesses |
| addr_o | output | 36 | Address after swizzling |
| unknown_o | output | 1 | Selected mode is the unknown code; the address is passed through |

## Verification
The bench sweeps every combination of tiling code, X mode and Y mode. For each combination it drives all 32 patterns of the bits at positions 6, 9, 10, 11 and 17, over two backgrounds of the remaining bits.

Each bug class shows up in a specific way:
- Swapped mode selection breaks R2 whenever the X and Y modes differ.
- A wrong or missing tap inverts bit 6 on half of the patterns.
- A reserved tiling code that reaches the swizzle path breaks R1.
- An unknown mode that still XORs, or that never raises the flag, breaks R10.
- Disturbing any other bit is caught by the non-zero background.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_e;

  typedef enum logic [2:0] {
    SWZ_OFF      = 3'd0,
    SWZ_A        = 3'd1,
    SWZ_AB       = 3'd2,
    SWZ_AC       = 3'd3,
    SWZ_ABC      = 3'd4,
    SWZ_AD       = 3'd5,
    SWZ_ABD      = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_mode_e;

endpackage

// File: rtl/swz_mode_sel.sv
module swz_mode_sel
  import swz_pkg::*;
(
  input  tile_e     tiling,
  input  swz_mode_e x_mode,
  input  swz_mode_e y_mode,
  output swz_mode_e sel_mode
);

  always_comb begin
    case (tiling)
      TILE_X:  sel_mode = x_mode;
      TILE_Y:  sel_mode = y_mode;
      default: sel_mode = SWZ_OFF;
    endcase
  end

endmodule

// File: rtl/swz_tap_decode.sv
module swz_tap_decode
  import swz_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int TAP_A  = 9,
  parameter int TAP_B  = 10,
  parameter int TAP_C  = 11,
  parameter int TAP_D  = 17
) (
  input  swz_mode_e         mode,
  output logic [ADDR_W-1:0] tap_mask,
  output logic              unknown
);

  always_comb begin
    tap_mask = '0;
    unknown  = 1'b0;
    case (mode)
      SWZ_OFF: ;
      SWZ_A:   tap_mask[TAP_A] = 1'b1;
      SWZ_AB:  begin tap_mask[TAP_A] = 1'b1; tap_mask[TAP_B] = 1'b1; end
      SWZ_AC:  begin tap_mask[TAP_A] = 1'b1; tap_mask[TAP_C] = 1'b1; end
      SWZ_ABC: begin
        tap_mask[TAP_A] = 1'b1; tap_mask[TAP_B] = 1'b1; tap_mask[TAP_C] = 1'b1;
      end
      SWZ_AD:  begin tap_mask[TAP_A] = 1'b1; tap_mask[TAP_D] = 1'b1; end
      SWZ_ABD: begin
        tap_mask[TAP_A] = 1'b1; tap_mask[TAP_B] = 1'b1; tap_mask[TAP_D] = 1'b1;
      end
      default: unknown = 1'b1;
    endcase
  end

  // R4..R9: every supported non-off mode includes the base tap
  always_comb begin
    if (!unknown && mode != SWZ_OFF)
      a_r4_base_tap_present: assert (tap_mask[TAP_A])
        else $error("base tap missing for mode %0d", mode);
  end

  // R10: unknown mode contributes no taps
  always_comb begin
    if (unknown)
      a_r10_unknown_no_taps: assert (tap_mask == '0)
        else $error("unknown mode has taps");
  end

endmodule

// File: rtl/swz_xor_core.sv
module swz_xor_core #(
  parameter int ADDR_W = 36,
  parameter int SWZ_BIT = 6
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] tap_mask,
  output logic [ADDR_W-1:0] addr_out
);

  localparam logic [ADDR_W-1:0] KEEP_MASK = ~({{(ADDR_W-1){1'b0}}, 1'b1} << SWZ_BIT);

  logic parity;

  always_comb begin
    parity            = ^(addr_in & tap_mask);
    addr_out          = addr_in;
    addr_out[SWZ_BIT] = addr_in[SWZ_BIT] ^ parity;
  end

  // R11: nothing but the swizzle bit may change
  always_comb begin
    a_r11_only_target_bit: assert (((addr_out ^ addr_in) & KEEP_MASK) == '0)
      else $error("bits other than the swizzle bit changed");
  end

endmodule

// File: rtl/bit6_swizzle.sv
module bit6_swizzle
  import swz_pkg::*;
#(
  parameter int ADDR_W  = 36,
  parameter int SWZ_BIT = 6,
  parameter int TAP_A   = 9,
  parameter int TAP_B   = 10,
  parameter int TAP_C   = 11,
  parameter int TAP_D   = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        tiling_i,
  input  logic [2:0]        x_mode_i,
  input  logic [2:0]        y_mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              unknown_o
);

  swz_mode_e         sel_mode;
  logic [ADDR_W-1:0] tap_mask;
  logic              unk;

  swz_mode_sel u_sel (
    .tiling   (tile_e'(tiling_i)),
    .x_mode   (swz_mode_e'(x_mode_i)),
    .y_mode   (swz_mode_e'(y_mode_i)),
    .sel_mode (sel_mode)
  );

  swz_tap_decode #(
    .ADDR_W (ADDR_W), .TAP_A (TAP_A), .TAP_B (TAP_B),
    .TAP_C  (TAP_C),  .TAP_D (TAP_D)
  ) u_dec (
    .mode     (sel_mode),
    .tap_mask (tap_mask),
    .unknown  (unk)
  );

  swz_xor_core #(.ADDR_W (ADDR_W), .SWZ_BIT (SWZ_BIT)) u_core (
    .addr_in  (addr_i),
    .tap_mask (tap_mask),
    .addr_out (addr_o)
  );

  assign unknown_o = unk;

  // R1: untiled and reserved codes pass through with no flag
  always_comb begin
    if (tiling_i == 2'd0 || tiling_i == 2'd3)
      a_r1_untiled_pass: assert (addr_o == addr_i && !unknown_o)
        else $error("untiled access altered");
  end

  // R10: a flagged access is never swizzled
  always_comb begin
    if (unknown_o)
      a_r10_unknown_pass: assert (addr_o == addr_i)
        else $error("unknown mode altered address");
  end

  // R3: off mode selected leaves the address intact
  always_comb begin
    if ((tiling_i == 2'd1 && x_mode_i == 3'd0) || (tiling_i == 2'd2 && y_mode_i == 3'd0))
      a_r3_off_pass: assert (addr_o == addr_i)
        else $error("off mode altered address");
  end

endmodule

// File: tb/tb_bit6_swizzle.sv
module tb_bit6_swizzle;

  logic clk;
  logic [35:0] addr_i, addr_o;
  logic [1:0]  tiling_i;
  logic [2:0]  x_mode_i, y_mode_i;
  logic        unknown_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  bit6_swizzle dut (
    .addr_i    (addr_i),
    .tiling_i  (tiling_i),
    .x_mode_i  (x_mode_i),
    .y_mode_i  (y_mode_i),
    .addr_o    (addr_o),
    .unknown_o (unknown_o)
  );

  function automatic bit tap_xor(input logic [2:0] m, input logic [35:0] a);
    case (m)
      3'd1: return a[9];
      3'd2: return a[9] ^ a[10];
      3'd3: return a[9] ^ a[11];
      3'd4: return a[9] ^ a[10] ^ a[11];
      3'd5: return a[9] ^ a[17];
      3'd6: return a[9] ^ a[10] ^ a[17];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_tag(input logic [1:0] t, input logic [2:0] m);
    if (t == 2'd0 || t == 2'd3) return "R1";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] bg [2];
    logic [35:0] a, exp_a;
    logic [2:0]  sm;
    bit          exp_u;
    bg[0] = 36'h0;
    bg[1] = 36'hA_5C3D_F1B7 & ~36'h0_0002_0E40;

    // reset-like initial state: everything zero
    addr_i = '0; tiling_i = '0; x_mode_i = '0; y_mode_i = '0;
    @(negedge clk);
    checks++;
    if (addr_o !== 36'h0 || unknown_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle actual %h/%b expected 0/0", addr_o, unknown_o);
    end

    for (int t = 0; t < 4; t++)
      for (int xm = 0; xm < 8; xm++)
        for (int ym = 0; ym < 8; ym++)
          for (int b = 0; b < 2; b++)
            for (int p = 0; p < 32; p++) begin
              @(posedge clk);
              a = bg[b];
              a[6] = p[0]; a[9] = p[1]; a[10] = p[2]; a[11] = p[3]; a[17] = p[4];
              addr_i = a; tiling_i = t[1:0]; x_mode_i = xm[2:0]; y_mode_i = ym[2:0];
              sm = (t == 1) ? xm[2:0] : (t == 2) ? ym[2:0] : 3'd0;
              exp_a = a;
              exp_u = (sm == 3'd7);
              exp_a[6] = a[6] ^ tap_xor(sm, a);
              @(negedge clk);
              checks++;
              // R2 and R11 are covered: mode chosen by tiling, background bits kept
              if (addr_o !== exp_a || unknown_o !== exp_u) begin
                errors++;
                $display("FAIL %s (R2/R11) t=%0d xm=%0d ym=%0d actual %h/%b expected %h/%b",
                         req_tag(t[1:0], sm), t, xm, ym, addr_o, unknown_o, exp_a, exp_u);
              end
            end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule